// File: doc/BRIEF.md
# Tracking Angle Counter with Busy Pulse and Built-In Test

This block is the digital half of a type-II tracking converter. The loop oscillator sends it step-up and step-down pulses, and it keeps them in a 16-bit natural-binary angle register. Bit 15 of the register weighs 180 degrees, and each lower bit weighs half of the bit above it. Every step moves the angle by one least-significant bit of the resolution in force, which can be 10, 12, 14 or 16 bits. Each step that is applied raises a busy pulse of fixed width. The rising edge of that pulse is the clock edge on which the angle changes. A host can therefore hold off reading the angle while busy is high.

The resolution request is only taken when a busy pulse ends, so a change of resolution can never split a count. If step pulses arrive while a busy pulse is running, they are held in a small signed pending count and applied one at a time, each with its own busy pulse. A built-in-test flag is high when the loop is healthy. It drops when the signed error magnitude is larger than a threshold of 65 LSBs, or when loss of signal or loss of reference is reported.

When the count-enable input is low, the block acts as a plain register. Step pulses are ignored and the angle is written one byte at a time from outside, which is the control-transformer use.

Top module: `trk_angle_counter`

## Requirements
- R1: While count_en is high, each applied step moves the angle output by exactly one LSB of the active resolution, up for step_up and down for step_dn. A step_up and a step_dn in the same cycle cancel: no busy pulse follows and the angle does not change.
- R2: Each applied step raises busy for exactly BUSY_CYC clock cycles (default 30 cycles, 0.6 us at 50 MHz). The angle changes on the same clock edge on which busy rises. Busy is low for at least one cycle between two pulses.
- R3: The resolution codes are 2'b00 = 10 bits, 2'b01 = 12 bits, 2'b10 = 14 bits and 2'b11 = 16 bits. The angle output is MSB-aligned, bit 15 weighs 180 degrees, and the bits below the active resolution always read 0.
- R4: res_sel is sampled during reset and on the clock edge on which busy falls. A change of res_sel at any other time has no effect on the step size or on the output mask until that edge.
- R5: The angle wraps modulo 2^16. At 10-bit resolution, a step down from 16'h0000 gives 16'hFFC0, and steps up from 16'hFFC0 carry through zero.
- R6: Step pulses that arrive while busy is high are queued as a net signed count, and every one of them is later applied with its own busy pulse. Up to PEND_MAX (default 7) net steps can be waiting without loss.
- R7: One cycle after the signed error err_lsb moves outside -65..+65, bit_ok reads 0. It reads 1 again one cycle after the error returns to that range with no loss flag set. The values +65 and -65 count as good.
- R8: One cycle after los or lor is high, bit_ok reads 0.
- R9: While count_en is low, step pulses are ignored: no busy pulse occurs, the angle does not move, and pending steps are discarded. On each clock edge, load_msb writes load_byte into angle bits 15:8 and load_lsb writes it into bits 7:0. While count_en is high, both load inputs have no effect.
- R10: After a synchronous active-low reset, angle is 16'h0000, busy is 0 and bit_ok is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| count_en | input | 1 | 1 = track the step pulses, 0 = external load mode |
| step_up | input | 1 | One-cycle pulse asking for an increment |
| step_dn | input | 1 | One-cycle pulse asking for a decrement |
| res_sel | input | 2 | Requested resolution code (00=10, 01=12, 10=14, 11=16 bits) |
| err_lsb | input | ERR_W | Signed loop error in LSBs of the active resolution |
| los | input | 1 | Loss of signal |
| lor | input | 1 | Loss of reference |
| load_msb | input | 1 | Write load_byte into angle bits 15:8 (load mode only) |
| load_lsb | input | 1 | Write load_byte into angle bits 7:0 (load mode only) |
| load_byte | input | 8 | Data for a byte load |
| angle | output | 16 | Masked, MSB-aligned angle |
| busy | output | 1 | High for BUSY_CYC cycles for each applied step |
| bit_ok | output | 1 | Built-in-test flag, 1 = healthy |

## Verification
The assertions check four things on every cycle: that a step changes the masked angle by exactly the step weight, that busy follows each applied step and stays high for exactly BUSY_CYC cycles, that the latched resolution moves only when busy falls, and that an error beyond the threshold or a loss flag pulls the test flag down. They also check that the pending count never has to saturate, and that load mode never starts a busy pulse. Some behaviours show up only in the bench's scenarios, because they depend on a chain of events. These are the delayed effect of a resolution change on the output mask, wrap-around through zero, a burst of queued pulses that all come out later, cancellation of same-cycle up and down requests, and byte loads whose value becomes the base for the next step.

// File: rtl/trk_pkg.sv
// Package trk_pkg
// Shared resolution type, angle width and the per-resolution step and mask.
// Assumes the angle register is always 16 bits wide and MSB aligned.
package trk_pkg;

    localparam int ANG_W  = 16;
    localparam int BYTE_W = ANG_W / 2;

    typedef enum logic [1:0] {
        RES10 = 2'b00,
        RES12 = 2'b01,
        RES14 = 2'b10,
        RES16 = 2'b11
    } res_e;

    // Weight of one LSB of the given resolution, in units of the 16-bit LSB.
    function automatic logic [ANG_W-1:0] step_of(input res_e r);
        logic [ANG_W-1:0] one;
        one = {{(ANG_W-1){1'b0}}, 1'b1};
        return one << (6 - 2 * int'(r));
    endfunction

    // Keeps the bits that belong to the given resolution.
    function automatic logic [ANG_W-1:0] mask_of(input res_e r);
        logic [ANG_W-1:0] ones;
        ones = '1;
        return ones << (6 - 2 * int'(r));
    endfunction

endpackage

// File: rtl/trk_step_queue.sv
// Module trk_step_queue
// Holds the net count of requested steps and releases them one at a time.
// Each release (fire) starts a busy pulse that is exactly BUSY_CYC cycles long.
// Assumes: step pulses are synchronous to clk; BUSY_CYC >= 2; PEND_W >= 3.
module trk_step_queue #(
    parameter int BUSY_CYC = 30,
    parameter int PEND_W   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic step_up,
    input  logic step_dn,
    output logic fire,
    output logic fire_up,
    output logic busy,
    output logic busy_end
);

    localparam int CNT_W = $clog2(BUSY_CYC);
    localparam int PMAX  = 2 ** (PEND_W - 1) - 1;

    logic signed [PEND_W-1:0] pend;
    logic signed [PEND_W-1:0] pend_nxt;
    logic signed [PEND_W:0]   delta;
    logic signed [PEND_W:0]   sum;
    logic [CNT_W-1:0]         cnt;
    logic [CNT_W:0]           hi_len;

    // Release a step when idle and something is pending; the sign gives the direction.
    assign fire     = count_en && !busy && (pend != '0);
    assign fire_up  = !pend[PEND_W-1];
    assign busy_end = busy && (cnt == '0);

    // Next pending count: add new requests, remove the step being released, saturate.
    always_comb begin
        delta = '0;
        if (step_up && !step_dn) begin
            delta = 1;
        end else if (step_dn && !step_up) begin
            delta = -1;
        end
        if (fire) begin
            delta = fire_up ? delta - 1 : delta + 1;
        end
        sum = {pend[PEND_W-1], pend} + delta;
        if (int'(sum) > PMAX) begin
            pend_nxt = PEND_W'(PMAX);
        end else if (int'(sum) < -PMAX) begin
            pend_nxt = PEND_W'(-PMAX);
        end else begin
            pend_nxt = sum[PEND_W-1:0];
        end
    end

    // Pending register; cleared while counting is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !count_en) begin
            pend <= '0;
        end else begin
            pend <= pend_nxt;
        end
    end

    // Busy timer: loads on release, counts down, drops after BUSY_CYC cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (fire) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(BUSY_CYC - 1);
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Independent measure of how long busy has been high, used by the checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len <= '0;
        end else if (busy) begin
            hi_len <= hi_len + 1'b1;
        end else begin
            hi_len <= '0;
        end
    end

    AST_BUSY_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (int'(hi_len) == BUSY_CYC)); // R2

    AST_PEND_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && int'(pend) == PMAX && step_up && !step_dn) |-> fire); // R6

    AST_PEND_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && int'(pend) == -PMAX && step_dn && !step_up) |-> fire); // R6

endmodule

// File: rtl/trk_angle_reg.sv
// Module trk_angle_reg
// The angle register with the resolution latch, stepping and byte loads.
// Assumes fire is never high while count_en is low, and that fire and busy_end
// never happen in the same cycle.
module trk_angle_reg
    import trk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             fire,
    input  logic             fire_up,
    input  logic             busy_end,
    input  logic [1:0]       res_sel,
    input  logic             load_msb,
    input  logic             load_lsb,
    input  logic [BYTE_W-1:0] load_byte,
    output logic [ANG_W-1:0] angle_out
);

    res_e             res_act;
    logic [ANG_W-1:0] ang;
    logic [ANG_W-1:0] mask;
    logic [ANG_W-1:0] step_w;

    // Step weight and output mask of the latched resolution.
    always_comb begin
        mask   = mask_of(res_act);
        step_w = step_of(res_act);
    end

    assign angle_out = ang & mask;

    // Resolution latch: taken in reset and when a busy pulse ends.
    always_ff @(posedge clk) begin
        if (!rst_n || busy_end) begin
            res_act <= res_e'(res_sel);
        end
    end

    // Angle register: byte loads in load mode, one-LSB steps in count mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ang <= '0;
        end else if (!count_en) begin
            if (load_msb) begin
                ang[ANG_W-1:BYTE_W] <= load_byte;
            end
            if (load_lsb) begin
                ang[BYTE_W-1:0] <= load_byte;
            end
        end else if (fire) begin
            ang <= fire_up ? (ang & mask) + step_w : (ang & mask) - step_w;
        end
    end

    AST_STEP_ONE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (($past(fire_up) ? angle_out - $past(angle_out)
                                  : $past(angle_out) - angle_out) == $past(step_w))); // R1

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !fire) |=> $stable(ang)); // R9

    AST_RES_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_end |=> $stable(res_act)); // R4

endmodule

// File: rtl/trk_bit_mon.sv
// Module trk_bit_mon
// Registered built-in-test flag: healthy only when the error magnitude is within
// ERR_LIMIT and neither loss flag is set.
// Assumes err_lsb is already scaled to LSBs of the active resolution.
module trk_bit_mon #(
    parameter int ERR_W     = 10,
    parameter int ERR_LIMIT = 65
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ERR_W-1:0] err_lsb,
    input  logic                    los,
    input  logic                    lor,
    output logic                    bit_ok
);

    logic signed [ERR_W:0] err_ext;
    logic [ERR_W:0]        mag;
    logic                  over;

    // Magnitude of the signed error, one bit wider so the most negative value fits.
    always_comb begin
        err_ext = {err_lsb[ERR_W-1], err_lsb};
        mag     = err_ext[ERR_W] ? unsigned'(-err_ext) : unsigned'(err_ext);
        over    = int'(mag) > ERR_LIMIT;
    end

    // Registered health flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_ok <= 1'b0;
        end else begin
            bit_ok <= !(over || los || lor);
        end
    end

    AST_BIT_ERR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (err_lsb > ERR_LIMIT || err_lsb < -ERR_LIMIT) |=> !bit_ok); // R7

    AST_BIT_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (los || lor) |=> !bit_ok); // R8

endmodule

// File: rtl/trk_angle_counter.sv
// Module trk_angle_counter (top)
// Tracking angle counter: step queue with busy pulse, angle register with
// resolution latch and byte loads, and the built-in-test monitor.
// Assumes every input is synchronous to clk.
module trk_angle_counter
    import trk_pkg::*;
#(
    parameter int BUSY_CYC  = 30,
    parameter int PEND_W    = 4,
    parameter int ERR_W     = 10,
    parameter int ERR_LIMIT = 65
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    count_en,
    input  logic                    step_up,
    input  logic                    step_dn,
    input  logic [1:0]              res_sel,
    input  logic signed [ERR_W-1:0] err_lsb,
    input  logic                    los,
    input  logic                    lor,
    input  logic                    load_msb,
    input  logic                    load_lsb,
    input  logic [7:0]              load_byte,
    output logic [15:0]             angle,
    output logic                    busy,
    output logic                    bit_ok
);

    logic fire;
    logic fire_up;
    logic busy_end;

    trk_step_queue #(
        .BUSY_CYC (BUSY_CYC),
        .PEND_W   (PEND_W)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .fire     (fire),
        .fire_up  (fire_up),
        .busy     (busy),
        .busy_end (busy_end)
    );

    trk_angle_reg u_angle (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (count_en),
        .fire      (fire),
        .fire_up   (fire_up),
        .busy_end  (busy_end),
        .res_sel   (res_sel),
        .load_msb  (load_msb),
        .load_lsb  (load_lsb),
        .load_byte (load_byte),
        .angle_out (angle)
    );

    trk_bit_mon #(
        .ERR_W     (ERR_W),
        .ERR_LIMIT (ERR_LIMIT)
    ) u_bit (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_lsb (err_lsb),
        .los     (los),
        .lor     (lor),
        .bit_ok  (bit_ok)
    );

    AST_BUSY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (busy && $stable(res_sel) || busy)); // R2

    AST_NO_BUSY_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !busy) |=> !busy); // R9

endmodule

// File: tb/trk_angle_counter_tb.sv
module trk_angle_counter_tb;

    localparam int BUSY = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_en = 1'b1;
    logic        step_up = 1'b0;
    logic        step_dn = 1'b0;
    logic [1:0]  res_sel = 2'b11;
    logic signed [9:0] err_lsb = '0;
    logic        los = 1'b0;
    logic        lor = 1'b0;
    logic        load_msb = 1'b0;
    logic        load_lsb = 1'b0;
    logic [7:0]  load_byte = '0;
    logic [15:0] angle;
    logic        busy;
    logic        bit_ok;

    int compared = 0;
    int mismatched = 0;
    int rises = 0;
    logic prev_busy = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    trk_angle_counter u_dut (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .step_up(step_up),
        .step_dn(step_dn), .res_sel(res_sel), .err_lsb(err_lsb), .los(los),
        .lor(lor), .load_msb(load_msb), .load_lsb(load_lsb),
        .load_byte(load_byte), .angle(angle), .busy(busy), .bit_ok(bit_ok)
    );

    // Count busy rising edges, sampled away from the active edge.
    always @(negedge clk) begin
        if (busy && !prev_busy) rises++;
        prev_busy = busy;
    end

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic up, input logic dn);
        @(negedge clk);
        step_up = up;
        step_dn = dn;
        @(negedge clk);
        step_up = 1'b0;
        step_dn = 1'b0;
    endtask

    task automatic t_reset;
        check("R10 angle", angle, 0);
        check("R10 busy", busy, 0);
        check("R10 bit_ok", bit_ok, 0);
    endtask

    task automatic t_single_up;
        int width;
        int waited;
        width = 0;
        waited = 0;
        pulse(1'b1, 1'b0);
        while (!busy && waited < 10) begin
            @(negedge clk);
            waited++;
        end
        while (busy && width < 200) begin
            @(negedge clk);
            width++;
        end
        check("R2 busy width", width, BUSY);
        check("R1 one step up at 16 bit", angle, 16'h0001);
        settle(3);
    endtask

    task automatic t_resolution;
        res_sel = 2'b00;
        settle(5);
        check("R4 no effect while idle", angle, 16'h0001);
        pulse(1'b1, 1'b0);
        settle(BUSY + 5);
        check("R3 unused bits zero after latch", angle, 16'h0000);
        pulse(1'b1, 1'b0);
        settle(BUSY + 5);
        check("R1 step of 64 at 10 bit", angle, 16'h0040);
    endtask

    task automatic t_wrap;
        pulse(1'b0, 1'b1);
        settle(BUSY + 5);
        check("R1 step down", angle, 16'h0000);
        pulse(1'b0, 1'b1);
        settle(BUSY + 5);
        check("R5 wrap below zero", angle, 16'hFFC0);
    endtask

    task automatic t_queue;
        int r0;
        r0 = rises;
        @(negedge clk);
        step_up = 1'b1;
        settle(3);
        step_up = 1'b0;
        settle(3 * (BUSY + 2) + 10);
        check("R6 all queued steps applied", angle, 16'h0080);
        check("R6 one busy per step", rises - r0, 3);
    endtask

    task automatic t_cancel;
        int r0;
        r0 = rises;
        pulse(1'b1, 1'b1);
        settle(BUSY + 5);
        check("R1 cancel keeps angle", angle, 16'h0080);
        check("R1 cancel gives no busy", rises - r0, 0);
    endtask

    task automatic t_bit;
        @(negedge clk); err_lsb = 10'sd65;
        @(negedge clk); check("R7 +65 is good", bit_ok, 1);
        err_lsb = 10'sd66;
        @(negedge clk); check("R7 +66 faults", bit_ok, 0);
        err_lsb = -10'sd65;
        @(negedge clk); check("R7 -65 is good", bit_ok, 1);
        err_lsb = -10'sd66;
        @(negedge clk); check("R7 -66 faults", bit_ok, 0);
        err_lsb = '0; los = 1'b1;
        @(negedge clk); check("R8 loss of signal", bit_ok, 0);
        los = 1'b0; lor = 1'b1;
        @(negedge clk); check("R8 loss of reference", bit_ok, 0);
        lor = 1'b0;
        @(negedge clk); check("R8 recovery", bit_ok, 1);
    endtask

    task automatic t_load_mode;
        int r0;
        r0 = rises;
        @(negedge clk); count_en = 1'b0;
        pulse(1'b1, 1'b0);
        settle(BUSY + 5);
        check("R9 step ignored angle", angle, 16'h0080);
        check("R9 step ignored busy", rises - r0, 0);
        @(negedge clk); load_msb = 1'b1; load_byte = 8'hA5;
        @(negedge clk); load_msb = 1'b0; load_lsb = 1'b1; load_byte = 8'h3C;
        @(negedge clk); load_lsb = 1'b0;
        check("R9 byte loads masked at 10 bit", angle, 16'hA500);
        res_sel = 2'b11;
        count_en = 1'b1;
        @(negedge clk); load_msb = 1'b1; load_byte = 8'h00;
        @(negedge clk); load_msb = 1'b0;
        check("R9 load ignored while counting", angle, 16'hA500);
        pulse(1'b0, 1'b1);
        settle(BUSY + 5);
        check("R4 step from loaded value", angle, 16'hA4C0);
        pulse(1'b1, 1'b0);
        settle(BUSY + 5);
        check("R4 new 16 bit step after latch", angle, 16'hA4C1);
    endtask

    initial begin
        settle(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_single_up();
        t_resolution();
        t_wrap();
        t_queue();
        t_cancel();
        t_bit();
        t_load_mode();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule